// File: doc/BRIEF.md
# Fastlock Charge-Pump Timeout Controller

This block picks which of two 3-bit charge-pump current codes drives the loop. A loop at rest uses the normal code. A loop that is slewing to a new frequency uses the fast code. Software starts a fast period by writing a gain bit of 1 together with each divider-counter (AB) load.

The fast period then ends in one of two ways, chosen by a mode bit:

- **Manual end (mode bit 0):** software ends it by writing the gain bit back to 0.
- **Automatic end (mode bit 1):** a counter of phase-detector cycles ends it after a programmed timeout. The block then clears its stored gain bit and signals that clear with a one-cycle pulse.

A global enable bit must be set before any fast period takes effect. A hold input stands for the power-down or counter-reset condition of the surrounding synthesizer. While hold is asserted, the timeout counter is kept in its load state. Analog current generation lies outside this block.

Top module: `fastlock_cp_ctrl`

## Requirements
- R1: After reset, cp_code equals cur_norm, fast_active is 0 and gain_clr is 0.
- R2: fast_active is 1 only when fl_en is 1 and the stored gain bit is 1. The stored gain bit is kept while fl_en is 0, so setting fl_en later makes fastlock active without a new write.
- R3: cp_code equals cur_fast while fast_active is 1, and cur_norm otherwise.
- R4: On a clock edge with ab_load high, the stored gain bit takes the value of ab_gain, and the outputs reflect it from the next cycle. Writing 0 ends fastlock in either mode, and this manual end does not pulse gain_clr.
- R5: With fl_mode = 0 (manual mode), pfd_tick has no effect: fastlock stays active and gain_clr stays 0 for any number of ticks.
- R6: With fl_mode = 1 (timed mode) and tmr_code = TC, fastlock stays active through 4*TC+2 pfd_tick pulses and ends on the edge of pulse number 4*TC+3. This gives a timeout of 3 to 63 cycles.
- R7: At the timed end, the stored gain bit becomes 0 and gain_clr is 1 for exactly the one cycle in which fast_active first reads 0.
- R8: The counter advances only while fl_mode = 1. Ticks seen in manual mode do not count, so a later switch to timed mode times a full 4*TC+3 ticks.
- R9: A write of ab_gain = 1 while a timed count runs restarts the count from zero, and a tick on that same edge is not counted.
- R10: While hold is 1, the counter is held at zero and ticks are not counted. The stored gain bit and fast_active are unchanged. After hold drops, a full 4*TC+3 ticks are needed.
- R11: A write of ab_gain = 1 on the same edge as the final tick wins over the timeout: there is no gain_clr pulse and fastlock stays active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_en | input | 1 | Fastlock enable bit |
| fl_mode | input | 1 | 0 = manual end, 1 = timed end |
| tmr_code | input | 4 | Timeout code TC (timeout = 4*TC+3 ticks) |
| cur_norm | input | 3 | Normal current code |
| cur_fast | input | 3 | Fastlock current code |
| ab_load | input | 1 | Strobe: AB counter load this cycle |
| ab_gain | input | 1 | Gain bit written with the AB load |
| pfd_tick | input | 1 | One-cycle strobe per phase-detector cycle |
| hold | input | 1 | Power-down or counter-reset hold |
| cp_code | output | 3 | Active current code |
| fast_active | output | 1 | Fastlock in effect |
| gain_clr | output | 1 | One-cycle pulse when the timeout clears the gain bit |

## Verification
The hardest situation to reach from the ports is a collision on the final counted tick. In that case a new gain write or a hold meets the timeout on the same edge, and the result depends on priority rather than on counting. The stimulus uses timeout code 0, whose 3-tick window makes the last tick easy to locate. It counts two ticks and then drives the third tick on the same edge as a gain-1 write. A hold is also applied partway through a count, and the full timeout length is checked again after the hold drops.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int TC_W   = 4;
  localparam int CODE_W = 3;

  // Length of a timed fastlock period, in phase-detector ticks.
  function automatic int fl_limit(input int tc);
    return 4 * tc + 3;
  endfunction

  // Counter width able to reach the largest limit.
  function automatic int fl_cnt_w(input int tc_w);
    return $clog2(fl_limit((1 << tc_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/fl_gain_reg.sv
module fl_gain_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ab_load,
  input  logic ab_gain,
  input  logic expire,
  output logic gain_bit,
  output logic clr_pulse
);
  // The write path has priority over the timeout clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_bit  <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      if (ab_load)     gain_bit <= ab_gain;
      else if (expire) gain_bit <= 1'b0;
      clr_pulse <= expire & ~ab_load;
    end
  end
endmodule

// File: rtl/fl_timeout_timer.sv
module fl_timeout_timer import fl_pkg::*; #(
  parameter int TC_W_P = TC_W,
  localparam int CNT_W = fl_cnt_w(TC_W_P)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              hold,
  input  logic              restart,
  input  logic              tick,
  input  logic [TC_W_P-1:0] tc,
  output logic [CNT_W-1:0]  cnt,
  output logic              expire
);
  logic at_last;

  // The >= compare keeps the timer from running away if tc shrinks mid-count.
  always_comb begin
    at_last = (32'(cnt) + 1) >= fl_limit(32'(tc));
    expire  = run & ~hold & ~restart & tick & at_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (hold || !run || restart)  cnt <= '0;
    else if (tick)                     cnt <= at_last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/fl_cur_mux.sv
module fl_cur_mux #(
  parameter int W = 3
) (
  input  logic         sel_fast,
  input  logic [W-1:0] code_norm,
  input  logic [W-1:0] code_fast,
  output logic [W-1:0] code_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign code_out[b] = sel_fast ? code_fast[b] : code_norm[b];
  end
endmodule

// File: rtl/fastlock_cp_ctrl.sv
module fastlock_cp_ctrl import fl_pkg::*; #(
  parameter int TC_W_P   = TC_W,
  parameter int CODE_W_P = CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fl_en,
  input  logic                fl_mode,
  input  logic [TC_W_P-1:0]   tmr_code,
  input  logic [CODE_W_P-1:0] cur_norm,
  input  logic [CODE_W_P-1:0] cur_fast,
  input  logic                ab_load,
  input  logic                ab_gain,
  input  logic                pfd_tick,
  input  logic                hold,
  output logic [CODE_W_P-1:0] cp_code,
  output logic                fast_active,
  output logic                gain_clr
);
  localparam int CNT_W = fl_cnt_w(TC_W_P);

  // Named internal events, visible to the bound checker.
  logic             gain_bit;
  logic             tmr_run;
  logic             tmr_restart;
  logic             tmr_expire;
  logic [CNT_W-1:0] tmr_cnt;

  assign tmr_run     = fl_en & fl_mode & gain_bit;
  assign tmr_restart = ab_load & ab_gain;
  assign fast_active = fl_en & gain_bit;

  fl_gain_reg i_gain (
    .clk       (clk),
    .rst_n     (rst_n),
    .ab_load   (ab_load),
    .ab_gain   (ab_gain),
    .expire    (tmr_expire),
    .gain_bit  (gain_bit),
    .clr_pulse (gain_clr)
  );

  fl_timeout_timer #(.TC_W_P(TC_W_P)) i_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_run),
    .hold    (hold),
    .restart (tmr_restart),
    .tick    (pfd_tick),
    .tc      (tmr_code),
    .cnt     (tmr_cnt),
    .expire  (tmr_expire)
  );

  fl_cur_mux #(.W(CODE_W_P)) i_mux (
    .sel_fast  (fast_active),
    .code_norm (cur_norm),
    .code_fast (cur_fast),
    .code_out  (cp_code)
  );
endmodule

// File: rtl/fl_cp_checker.sv
module fl_cp_checker #(
  parameter int CODE_W_P = 3,
  parameter int CNT_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fl_en,
  input logic                fl_mode,
  input logic                ab_load,
  input logic                ab_gain,
  input logic                pfd_tick,
  input logic                hold,
  input logic [CODE_W_P-1:0] cur_norm,
  input logic [CODE_W_P-1:0] cur_fast,
  input logic [CODE_W_P-1:0] cp_code,
  input logic                fast_active,
  input logic                gain_clr,
  input logic                gain_bit,
  input logic [CNT_W-1:0]    tmr_cnt
);
  p_code_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cp_code == (fast_active ? cur_fast : cur_norm));

  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |=> !gain_clr);

  p_clr_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |-> !gain_bit && !fast_active);

  p_clr_needs_timed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |-> $past(fl_mode) && $past(fl_en) && $past(pfd_tick) && !$past(ab_load));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ab_load |=> gain_bit == $past(ab_gain));

  p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> tmr_cnt == '0);

  p_hold_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !ab_load |=> $stable(gain_bit));

  p_manual_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_mode |=> tmr_cnt == '0);
endmodule

bind fastlock_cp_ctrl fl_cp_checker #(.CODE_W_P(CODE_W_P), .CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fl_en       (fl_en),
  .fl_mode     (fl_mode),
  .ab_load     (ab_load),
  .ab_gain     (ab_gain),
  .pfd_tick    (pfd_tick),
  .hold        (hold),
  .cur_norm    (cur_norm),
  .cur_fast    (cur_fast),
  .cp_code     (cp_code),
  .fast_active (fast_active),
  .gain_clr    (gain_clr),
  .gain_bit    (gain_bit),
  .tmr_cnt     (tmr_cnt)
);

// File: tb/test_fastlock_cp_ctrl.sv
module test_fastlock_cp_ctrl;
  localparam time CLK_P = 10ns;

  // Timed-mode vectors: timer code, expected tick count, normal and fast codes.
  localparam int NV = 5;
  localparam logic [3:0] TV_TC   [NV] = '{4'd0, 4'd1, 4'd5, 4'd10, 4'd15};
  localparam int         TV_LEN  [NV] = '{3, 7, 23, 43, 63};
  localparam logic [2:0] TV_NORM [NV] = '{3'd1, 3'd0, 3'd2, 3'd6, 3'd3};
  localparam logic [2:0] TV_FAST [NV] = '{3'd7, 3'd5, 3'd4, 3'd1, 3'd0};

  logic       clk = 1'b0;
  logic       rst_n, fl_en, fl_mode, ab_load, ab_gain, pfd_tick, hold;
  logic [3:0] tmr_code;
  logic [2:0] cur_norm, cur_fast, cp_code;
  logic       fast_active, gain_clr;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_P/2) clk = ~clk;

  fastlock_cp_ctrl i_fastlock_cp_ctrl (
    .clk(clk), .rst_n(rst_n), .fl_en(fl_en), .fl_mode(fl_mode),
    .tmr_code(tmr_code), .cur_norm(cur_norm), .cur_fast(cur_fast),
    .ab_load(ab_load), .ab_gain(ab_gain), .pfd_tick(pfd_tick), .hold(hold),
    .cp_code(cp_code), .fast_active(fast_active), .gain_clr(gain_clr));

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Inputs change just after a falling edge; results are read at falling edges.
  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      pfd_tick = 1'b1;
      @(negedge clk);
      pfd_tick = 1'b0;
    end
  endtask

  task automatic ab_write(input logic g);
    ab_load = 1'b1;
    ab_gain = g;
    @(negedge clk);
    ab_load = 1'b0;
    ab_gain = 1'b0;
  endtask

  task automatic end_check(input string req, input logic [2:0] nrm);
    chk({req, " active low at end"}, int'(fast_active), 0);
    chk({req, " clr pulse"}, int'(gain_clr), 1);
    chk({req, " normal code"}, int'(cp_code), int'(nrm));
    @(negedge clk);
    chk({req, " clr one cycle"}, int'(gain_clr), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fl_en = 1'b0; fl_mode = 1'b0; ab_load = 1'b0; ab_gain = 1'b0;
    pfd_tick = 1'b0; hold = 1'b0; tmr_code = 4'd0; cur_norm = 3'd2; cur_fast = 3'd6;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 code", int'(cp_code), 2);
    chk("R1 active", int'(fast_active), 0);
    chk("R1 clr", int'(gain_clr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: timed mode, R6 / R7 / R3
    for (int v = 0; v < NV; v++) begin
      fl_en = 1'b1; fl_mode = 1'b1; tmr_code = TV_TC[v];
      cur_norm = TV_NORM[v]; cur_fast = TV_FAST[v];
      ab_write(1'b1);
      chk("R3 fast code", int'(cp_code), int'(TV_FAST[v]));
      tick_n(TV_LEN[v] - 1);
      chk("R6 still active", int'(fast_active), 1);
      chk("R7 no early clr", int'(gain_clr), 0);
      tick_n(1);
      end_check("R6 R7", TV_NORM[v]);
      tick_n(4);
      chk("R7 stays ended", int'(fast_active), 0);
    end

    cur_norm = 3'd2; cur_fast = 3'd6;

    // R2: enable gates the stored bit
    fl_en = 1'b0; fl_mode = 1'b0;
    ab_write(1'b1);
    chk("R2 disabled inactive", int'(fast_active), 0);
    chk("R2 disabled code", int'(cp_code), 2);
    fl_en = 1'b1;
    @(negedge clk);
    chk("R2 enable later", int'(fast_active), 1);
    chk("R3 code fast", int'(cp_code), 6);

    // R5: manual mode ignores ticks
    tick_n(100);
    chk("R5 still active", int'(fast_active), 1);
    chk("R5 no clr", int'(gain_clr), 0);

    // R4: manual end by writing 0, no pulse
    ab_write(1'b0);
    chk("R4 ended", int'(fast_active), 0);
    chk("R4 no clr", int'(gain_clr), 0);
    chk("R4 code", int'(cp_code), 2);

    // R8: ticks in manual mode do not count
    ab_write(1'b1);
    tick_n(40);
    fl_mode = 1'b1; tmr_code = 4'd0;
    @(negedge clk);
    tick_n(2);
    chk("R8 full window", int'(fast_active), 1);
    tick_n(1);
    end_check("R8", 3'd2);

    // R9: rewrite restarts the count (TC=1 -> 7 ticks)
    tmr_code = 4'd1;
    ab_write(1'b1);
    tick_n(5);
    ab_write(1'b1);
    tick_n(6);
    chk("R9 restarted", int'(fast_active), 1);
    chk("R9 no clr", int'(gain_clr), 0);
    tick_n(1);
    end_check("R9", 3'd2);

    // R9: tick on the restart edge is not counted (TC=0)
    tmr_code = 4'd0;
    ab_write(1'b1);
    tick_n(1);
    pfd_tick = 1'b1;
    ab_write(1'b1);
    pfd_tick = 1'b0;
    tick_n(2);
    chk("R9 tick on write ignored", int'(fast_active), 1);
    tick_n(1);
    end_check("R9 same edge", 3'd2);

    // R10: hold forces the counter to zero
    ab_write(1'b1);
    tick_n(2);
    hold = 1'b1;
    tick_n(5);
    chk("R10 active during hold", int'(fast_active), 1);
    chk("R10 no clr during hold", int'(gain_clr), 0);
    hold = 1'b0;
    @(negedge clk);
    tick_n(2);
    chk("R10 full window after hold", int'(fast_active), 1);
    tick_n(1);
    end_check("R10", 3'd2);

    // R11: write on the final tick wins
    ab_write(1'b1);
    tick_n(2);
    pfd_tick = 1'b1;
    ab_write(1'b1);
    pfd_tick = 1'b0;
    chk("R11 active", int'(fast_active), 1);
    chk("R11 no clr", int'(gain_clr), 0);
    tick_n(2);
    chk("R11 restarted window", int'(fast_active), 1);
    tick_n(1);
    end_check("R11", 3'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule